// File: doc/BRIEF.md
# Power-Mode and Fail-Safe Watchdog Controller

This block chooses the operating mode of a multi-channel smart output switch. It samples three slow control pins: a wake request, a run request and a fail-safe enable. It also takes per-channel fault flags and the words that arrive from an external serial shifter. From these it selects one of four modes: Sleep, Normal, Fault and Fail-Safe.

It drives the enable of every output channel. It also raises a select flag that tells the output stage to use a fixed fail-safe pattern instead of the programmed one, and a one-cycle clear pulse for the configuration register. Each accepted word carries the programmed channel states, a watchdog enable and a watchdog toggle bit. Flipping the toggle bit refreshes the watchdog.

A rising edge on the wake or run pin arms the watchdog, provided the fail-safe pin is high. An armed, enabled watchdog that is not refreshed in time puts the block into Fail-Safe. Fail-Safe holds until one of two events: wake and run fall in the same sampled cycle, or the fail-safe pin is pulsed low.

Words enter on a valid/ready port. `frame_ready` is low while wake and run are both low, and the block then refuses words. At all other times `frame_ready` is high, and a word is taken on any clock edge where `frame_valid` and `frame_ready` are both high. A sender whose word is refused must hold it steady with `frame_valid` high until the word is taken.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is Sleep, every output enable is 0 and `fs_sel` is 0. Modes are encoded on `mode` as 2'b00 Sleep, 2'b01 Normal, 2'b10 Fault and 2'b11 Fail-Safe.
- R2: When wake and run are both low after synchronization, and the block is not held in Fail-Safe:
  - the mode is Sleep and all output enables are 0;
  - `frame_ready` is 0;
  - the stored configuration is cleared to zero;
  - `cfg_clr` pulses for exactly one cycle on entry to this condition.

  With run low and wake high the mode is also Sleep, but the configuration is kept and no clear pulse is raised.
- R3: With run high and no fault, the mode is Normal and `out_en` equals bits [NUM_OUT-1:0] of the last accepted word.
- R4: A set `fault_in` bit puts the block in Fault and forces that channel's enable to 0 from the next cycle on. The other channels keep their programmed state.
- R5: Fault persists after the fault flags clear. The block returns to Normal only when a word is accepted while no fault flag is set.
- R6: Word bit 14 is the watchdog enable and bit 15 is the toggle bit. An accepted word whose bit 15 differs from the stored bit 15 refreshes the watchdog. Running for TIMEOUT cycles in Normal or Fault without a refresh enters Fail-Safe, where `out_en` equals FS_PATTERN and `fs_sel` is 1.
- R7: The watchdog runs only after it is armed. Arming is a synchronized rising edge on wake or run while the fail-safe pin is high. A low fail-safe pin or a Sleep clear disarms it, and the watchdog never times out while it is unarmed.
- R8: Fail-Safe is left for Sleep when wake and run fall in the same sampled cycle. Falling one at a time leaves the block in Fail-Safe. A low pulse on the fail-safe pin also leaves Fail-Safe, into the mode that the run pin and the fault state select.
- R9: While the fail-safe pin is held low, Fail-Safe is never entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wake_pin | input | 1 | Wake request pin, asynchronous |
| run_pin | input | 1 | Run request pin, asynchronous |
| fsi_pin | input | 1 | Fail-safe enable pin, asynchronous; low disables fail-safe |
| fault_in | input | NUM_OUT | Per-channel fault flags |
| frame_valid | input | 1 | Received word is valid |
| frame_ready | output | 1 | Block can take a word |
| frame_data | input | 16 | Received word: channel states, watchdog enable (bit 14), toggle (bit 15) |
| mode | output | 2 | Current mode |
| out_en | output | NUM_OUT | Final channel enables |
| fs_sel | output | 1 | Fixed fail-safe pattern selected |
| cfg_clr | output | 1 | One-cycle configuration clear pulse |

## Verification
The checker assumes that the pins are already synchronized and that edges are measured cycle against cycle. It also assumes that a fault flag seen in a cycle that is not Fail-Safe reaches the channel gating one edge later. The stimulus changes pins only at falling clock edges and holds each level for several cycles. When a simultaneous fall is needed, wake and run change on the same edge. When a one-at-a-time fall is needed, they change on different edges. Words are presented only while `frame_ready` is high, so no word is ever held waiting.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    PM_SLEEP  = 2'b00,
    PM_NORMAL = 2'b01,
    PM_FAULT  = 2'b10,
    PM_FSAFE  = 2'b11
  } pm_mode_e;

  localparam int WORD_W  = 16;
  localparam int WD_EN_B = 14;
  localparam int WD_TG_B = 15;
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out,
  output logic [W-1:0] sync_prev
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= async_in[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign sync_out[i]  = s2;
    assign sync_prev[i] = s3;
  end
endmodule

// File: rtl/pm_wdog.sv
module pm_wdog #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic refresh,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LOAD = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= LOAD;
    else if (!run_en || refresh) cnt <= LOAD;
    else if (cnt != '0)         cnt <= cnt - 1'b1;
  end

  assign expired = run_en && !refresh && (cnt == '0);
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter logic [NUM_OUT-1:0] FS_PATTERN = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wake_s,
  input  logic               run_s,
  input  logic               fsi_s,
  input  logic               sim_fall,
  input  logic               fsi_fall,
  input  logic               arm_edge,
  input  logic [NUM_OUT-1:0] fault_in,
  input  logic               accept,
  input  logic [WORD_W-1:0]  word,
  input  logic               wd_expired,
  output logic               wd_run,
  output logic               wd_refresh,
  output pm_mode_e           mode,
  output logic [NUM_OUT-1:0] out_en,
  output logic               fs_sel,
  output logic               cfg_clr
);
  logic [NUM_OUT-1:0] cmd_q, flt_q, flt_n;
  logic               wd_en_q, wd_tg_q, armed_q, clr_d;
  logic               fs_hold, clr_now;
  pm_mode_e           mode_n;

  assign fs_hold    = (mode == PM_FSAFE) && !(sim_fall || fsi_fall);
  assign clr_now    = !wake_s && !run_s && !fs_hold;
  assign wd_refresh = accept && (word[WD_TG_B] != wd_tg_q);
  assign wd_run     = armed_q && fsi_s && wd_en_q &&
                      ((mode == PM_NORMAL) || (mode == PM_FAULT));

  always_comb begin
    if (clr_now)     flt_n = '0;
    else if (accept) flt_n = fault_in;
    else             flt_n = flt_q | fault_in;
  end

  always_comb begin
    if (fs_hold)         mode_n = PM_FSAFE;
    else if (!run_s)     mode_n = PM_SLEEP;
    else if (wd_expired) mode_n = PM_FSAFE;
    else if (|flt_n)     mode_n = PM_FAULT;
    else                 mode_n = PM_NORMAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      wd_en_q <= 1'b0;
      wd_tg_q <= 1'b0;
    end else if (clr_now) begin
      cmd_q   <= '0;
      wd_en_q <= 1'b0;
      wd_tg_q <= 1'b0;
    end else if (accept) begin
      cmd_q   <= word[NUM_OUT-1:0];
      wd_en_q <= word[WD_EN_B];
      wd_tg_q <= word[WD_TG_B];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q   <= '0;
      armed_q <= 1'b0;
      mode    <= PM_SLEEP;
      clr_d   <= 1'b1;
      cfg_clr <= 1'b0;
    end else begin
      flt_q   <= flt_n;
      mode    <= mode_n;
      clr_d   <= clr_now;
      cfg_clr <= clr_now && !clr_d;
      if (!fsi_s || clr_now) armed_q <= 1'b0;
      else if (arm_edge)     armed_q <= 1'b1;
    end
  end

  always_comb begin
    fs_sel = 1'b0;
    unique case (mode)
      PM_SLEEP:  out_en = '0;
      PM_FSAFE: begin
        out_en = FS_PATTERN;
        fs_sel = 1'b1;
      end
      default:   out_en = cmd_q & ~flt_q;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int TIMEOUT = 64,
  parameter logic [NUM_OUT-1:0] FS_PATTERN = 4'b1001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wake_pin,
  input  logic               run_pin,
  input  logic               fsi_pin,
  input  logic [NUM_OUT-1:0] fault_in,
  input  logic               frame_valid,
  output logic               frame_ready,
  input  logic [15:0]        frame_data,
  output logic [1:0]         mode,
  output logic [NUM_OUT-1:0] out_en,
  output logic               fs_sel,
  output logic               cfg_clr
);
  logic [2:0] pin_s, pin_d;
  logic wake_s, run_s, fsi_s, wake_d, run_d, fsi_d;
  logic sim_fall, fsi_fall, arm_edge, accept;
  logic wd_run, wd_refresh, wd_expired;
  pm_mode_e mode_e;

  pm_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({fsi_pin, run_pin, wake_pin}),
    .sync_out(pin_s), .sync_prev(pin_d)
  );

  assign {fsi_s, run_s, wake_s} = pin_s;
  assign {fsi_d, run_d, wake_d} = pin_d;
  assign sim_fall    = wake_d && run_d && !wake_s && !run_s;
  assign fsi_fall    = fsi_d && !fsi_s;
  assign arm_edge    = fsi_s && ((wake_s && !wake_d) || (run_s && !run_d));
  assign frame_ready = wake_s || run_s;
  assign accept      = frame_valid && frame_ready;

  pm_wdog #(.TIMEOUT(TIMEOUT)) u_wdog (
    .clk(clk), .rst_n(rst_n), .run_en(wd_run),
    .refresh(wd_refresh), .expired(wd_expired)
  );

  pm_ctrl #(.NUM_OUT(NUM_OUT), .FS_PATTERN(FS_PATTERN)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wake_s(wake_s), .run_s(run_s), .fsi_s(fsi_s),
    .sim_fall(sim_fall), .fsi_fall(fsi_fall), .arm_edge(arm_edge),
    .fault_in(fault_in), .accept(accept), .word(frame_data),
    .wd_expired(wd_expired), .wd_run(wd_run), .wd_refresh(wd_refresh),
    .mode(mode_e), .out_en(out_en), .fs_sel(fs_sel), .cfg_clr(cfg_clr)
  );

  assign mode = mode_e;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int NUM_OUT = 4,
  parameter logic [NUM_OUT-1:0] FS_PATTERN = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         mode,
  input logic [NUM_OUT-1:0] out_en,
  input logic               fs_sel,
  input logic               cfg_clr,
  input logic [NUM_OUT-1:0] fault_in,
  input logic               wake_s,
  input logic               run_s,
  input logic               fsi_s,
  input logic               wake_d,
  input logic               run_d,
  input logic               fsi_d
);
  AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (out_en == '0 && !fs_sel)); // R2
  AST_CLR_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clr |-> (mode == 2'b00)); // R2
  AST_FAULT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((fault_in != '0) && (mode != 2'b11)) |=>
      ((mode == 2'b11) || ((out_en & $past(fault_in)) == '0))); // R4
  AST_FS_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> (fs_sel && out_en == FS_PATTERN)); // R6
  AST_FS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'b11) && !(wake_d && run_d && !wake_s && !run_s) && !(fsi_d && !fsi_s))
      |=> (mode == 2'b11)); // R8
  AST_FSI_LOW_NO_FS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsi_s && mode != 2'b11) |=> (mode != 2'b11)); // R9
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.NUM_OUT(NUM_OUT), .FS_PATTERN(FS_PATTERN)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .out_en(out_en), .fs_sel(fs_sel),
  .cfg_clr(cfg_clr), .fault_in(fault_in),
  .wake_s(wake_s), .run_s(run_s), .fsi_s(fsi_s),
  .wake_d(wake_d), .run_d(run_d), .fsi_d(fsi_d)
);

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;
  localparam int N = 4;
  localparam logic [N-1:0] FSP = 4'b1001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wake_pin = 0, run_pin = 0, fsi_pin = 0;
  logic [N-1:0] fault_in = '0;
  logic frame_valid = 0;
  logic [15:0] frame_data = '0;
  logic frame_ready, fs_sel, cfg_clr;
  logic [1:0] mode;
  logic [N-1:0] out_en;

  int tests = 0, fails = 0, clr_cnt = 0;
  bit done = 0;

  typedef struct {
    string tag;
    logic [1:0] m;
    logic [N-1:0] o;
    logic f;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.NUM_OUT(N), .TIMEOUT(64), .FS_PATTERN(FSP)) uut (
    .clk(clk), .rst_n(rst_n), .wake_pin(wake_pin), .run_pin(run_pin),
    .fsi_pin(fsi_pin), .fault_in(fault_in), .frame_valid(frame_valid),
    .frame_ready(frame_ready), .frame_data(frame_data), .mode(mode),
    .out_en(out_en), .fs_sel(fs_sel), .cfg_clr(cfg_clr)
  );

  always @(posedge clk) if (rst_n && cfg_clr) clr_cnt++;

  // monitor: pops expectations and compares against outputs
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      tests++;
      if (mode !== e.m || out_en !== e.o || fs_sel !== e.f) begin
        fails++;
        $display("FAIL %s: got mode=%b out=%b fs=%b, expected mode=%b out=%b fs=%b",
                 e.tag, mode, out_en, fs_sel, e.m, e.o, e.f);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(input string tag, input logic [1:0] m,
                           input logic [N-1:0] o, input logic f);
    exp_t e;
    e.tag = tag; e.m = m; e.o = o; e.f = f;
    sb.push_back(e);
    cyc(1);
  endtask

  task automatic check_val(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    frame_valid = 1'b1;
    frame_data  = w;
    cyc(1);
    frame_valid = 1'b0;
    cyc(3);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : driver
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    expect_st("R1 reset state", 2'b00, 4'b0000, 1'b0);
    check_val("R2 ready low in sleep", frame_ready, 0);

    fsi_pin = 1; run_pin = 1;
    cyc(6);
    expect_st("R3 normal after run", 2'b01, 4'b0000, 1'b0);
    check_val("R3 ready in normal", frame_ready, 1);
    send(16'hC005);
    expect_st("R3 programmed outputs", 2'b01, 4'b0101, 1'b0);

    for (int k = 0; k < 5; k++) begin
      cyc(30);
      send((k % 2 == 0) ? 16'h4005 : 16'hC005);
    end
    expect_st("R6 refreshed stays normal", 2'b01, 4'b0101, 1'b0);
    cyc(80);
    expect_st("R6 timeout to fail-safe", 2'b11, FSP, 1'b1);

    run_pin = 0;
    cyc(6);
    expect_st("R8 single fall keeps fail-safe", 2'b11, FSP, 1'b1);
    wake_pin = 1; run_pin = 1;
    cyc(6);
    expect_st("R8 rises keep fail-safe", 2'b11, FSP, 1'b1);
    check_val("R2 no clear in fail-safe", clr_cnt, 0);
    wake_pin = 0; run_pin = 0;
    cyc(6);
    expect_st("R8 joint fall to sleep", 2'b00, 4'b0000, 1'b0);
    check_val("R2 one clear pulse", clr_cnt, 1);

    run_pin = 1;
    cyc(6);
    expect_st("R2 config cleared", 2'b01, 4'b0000, 1'b0);
    send(16'h000F);
    expect_st("R3 all on", 2'b01, 4'b1111, 1'b0);
    fault_in = 4'b0010;
    cyc(3);
    expect_st("R4 fault gates channel", 2'b10, 4'b1101, 1'b0);
    fault_in = 4'b0000;
    cyc(3);
    expect_st("R5 fault persists", 2'b10, 4'b1101, 1'b0);
    send(16'h000F);
    expect_st("R5 recommand to normal", 2'b01, 4'b1111, 1'b0);

    fsi_pin = 0;
    cyc(4);
    send(16'h400F);
    cyc(150);
    expect_st("R9 fsi low never fail-safe", 2'b01, 4'b1111, 1'b0);
    fsi_pin = 1;
    cyc(150);
    expect_st("R7 unarmed no timeout", 2'b01, 4'b1111, 1'b0);

    wake_pin = 1;
    cyc(4);
    run_pin = 0;
    cyc(6);
    expect_st("R2 run low wake high sleep", 2'b00, 4'b0000, 1'b0);
    check_val("R2 no clear with wake high", clr_cnt, 1);
    run_pin = 1;
    cyc(80);
    expect_st("R7 armed by run rise times out", 2'b11, FSP, 1'b1);

    fsi_pin = 0;
    cyc(3);
    fsi_pin = 1;
    cyc(6);
    expect_st("R8 fsi pulse leaves fail-safe", 2'b01, 4'b1111, 1'b0);

    cyc(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule